// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a slave on a two-wire serial bus (I2C-style open-drain signalling) that gives a bus host access to a small register file. The SCL and SDA pad levels arrive already buffered. They are synchronised to the system clock, which runs much faster than the bus, and the block watches them for edges. Each line passes through a two-stage synchroniser followed by an edge detector. The block drives SDA only by asserting a pull-low enable. The pad and its pull-up resistor sit outside the block.

A transfer starts with a START condition. The host then sends a 7-bit device address and a direction bit. The upper six address bits are fixed at binary 010110. The lowest bit comes from a strap input, so two such slaves can share one bus. A write carries a register-select byte and then one data byte. A read carries a register-select byte, then a repeated START, then the address with the read direction, and then the slave returns one byte.

The register map is sparse. Two read/write control registers appear on output ports. One read-only status register reflects an input port. Each access moves exactly one byte, and the register pointer never advances by itself.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset both control registers read 00h and the pull-low enable `sda_pull` is 0 (SDA released).
- R2: The block acknowledges an address byte by asserting `sda_pull` during the ninth clock only when the byte's upper seven bits, sent MSB first, equal binary 010110 followed by `addr_strap`. For any other address it never asserts `sda_pull` before the next START.
- R3: A write consists of the address with direction bit 0, a register-select byte and one data byte, each of which the block acknowledges. At the end of the data byte, the data is stored in the selected control register (select 10h → `ctl_a_q`, select 11h → `ctl_b_q`).
- R4: A read consists of the address with direction bit 0, a select byte, a repeated START, and the address with direction bit 1. The block then sends 8 bits MSB first from the selected register: 10h control A, 11h control B, 13h the value of `status_in` at the end of the address acknowledge. Repeating the sequence with the same select returns the same register.
- R5: A write to select 13h or to any select other than 10h, 11h or 13h is acknowledged and changes no register. A read from an unmapped select returns 00h.
- R6: After the eighth bit of a read byte, the block releases SDA. It leaves SDA released through the host's acknowledge clock and until the next START.
- R7: A START received at any point restarts address reception, and a STOP received at any point ends the transfer. In both cases a partly received data byte is discarded.
- R8: `sda_pull` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |
| addr_strap | input | 1 | Lowest bit of the device address |
| status_in | input | 8 | Live value presented at select 13h |
| sda_pull | output | 1 | 1 pulls the SDA pad low |
| ctl_a_q | output | 8 | Control register A (select 10h) |
| ctl_b_q | output | 8 | Control register B (select 11h) |

## Verification
The bus-condition detector and the byte engine compete for the same transfer. A STOP or START can arrive while a data byte is only partly shifted in, and that condition has to win over the register write that would otherwise complete at that byte's eighth clock. The bench provokes this in two ways. It sends a STOP after four data bits, and it sends a repeated START after three data bits followed by a complete new write. It judges the result from the control-register ports: the aborted byte must not appear there, while the write that follows must land. A second overlap lets the write path also serve a read. A register select followed directly by a repeated START has to load the pointer without storing anything, and the bench judges this by the returned byte and by unchanged control registers.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_ACK,
    ST_TX
  } tw_state_e;

  typedef enum logic [1:0] {
    NX_IDLE,
    NX_CMD,
    NX_WDATA,
    NX_TX
  } tw_next_e;

  // Address byte match: seven MSBs against prefix plus strap.
  function automatic logic addr_hit(input logic [6:0] upper7,
                                    input logic [5:0] prefix,
                                    input logic       strap);
    return upper7 == {prefix, strap};
  endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_in};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank #(
  parameter int          DW       = 8,
  parameter logic [7:0]  SEL_CTLA = 8'h10,
  parameter logic [7:0]  SEL_CTLB = 8'h11,
  parameter logic [7:0]  SEL_STAT = 8'h13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    sel,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] status_in,
  output logic [DW-1:0] ctl_a,
  output logic [DW-1:0] ctl_b,
  output logic [DW-1:0] rd_data
);
  function automatic logic [DW-1:0] lookup(input logic [7:0]    s,
                                           input logic [DW-1:0] a,
                                           input logic [DW-1:0] b,
                                           input logic [DW-1:0] st);
    case (s)
      SEL_CTLA: return a;
      SEL_CTLB: return b;
      SEL_STAT: return st;
      default:  return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a <= '0;
      ctl_b <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CTLA) ctl_a <= wr_data;
      else if (sel == SEL_CTLB) ctl_b <= wr_data;
    end
  end

  assign rd_data = lookup(sel, ctl_a, ctl_b, status_in);
endmodule

// File: rtl/tw_xfer_fsm.sv
module tw_xfer_fsm
  import tw_reg_pkg::*;
#(
  parameter int         DW     = 8,
  parameter logic [5:0] PREFIX = 6'b010110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          strap,
  input  logic [DW-1:0] rd_data,
  output logic          sda_pull,
  output logic [7:0]    sel,
  output logic [DW-1:0] wr_data,
  output logic          wr_fire,
  output logic          ack_fire,
  output logic          tx_done,
  output logic          in_idle,
  output logic          in_addr
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_RX = CW'(DW);
  localparam logic [CW-1:0] LAST_TX = CW'(DW - 1);

  tw_state_e     st;
  tw_next_e      nx;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, txsr;
  logic          rx_state, byte_end, hit, bus_evt;

  assign rx_state = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_WDATA);
  assign bus_evt  = start_det | stop_det;
  assign byte_end = rx_state && scl_fall && (cnt == LAST_RX) && !bus_evt;
  assign hit      = addr_hit(sh[DW-1:1], PREFIX, strap);
  assign wr_fire  = byte_end && (st == ST_WDATA);
  assign ack_fire = byte_end && ((st != ST_ADDR) || hit);
  assign tx_done  = (st == ST_TX) && scl_fall && (cnt == LAST_TX) && !bus_evt;
  assign in_idle  = (st == ST_IDLE);
  assign in_addr  = (st == ST_ADDR);
  assign wr_data  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; nx <= NX_IDLE; cnt <= '0;
      sh <= '0; txsr <= '0; sel <= '0; sda_pull <= 1'b0;
    end else if (start_det) begin
      st <= ST_ADDR; cnt <= '0; sda_pull <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE; cnt <= '0; sda_pull <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise) begin
            sh  <= {sh[DW-2:0], sda_lvl};
            cnt <= cnt + 1'b1;
          end else if (byte_end) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (hit) begin
                sda_pull <= 1'b1; st <= ST_ACK;
                nx <= sh[0] ? NX_TX : NX_CMD;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              sda_pull <= 1'b1; st <= ST_ACK;
              if (st == ST_CMD) begin
                sel <= sh[7:0]; nx <= NX_WDATA;
              end else begin
                nx <= NX_IDLE;
              end
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          cnt <= '0;
          case (nx)
            NX_TX:    begin st <= ST_TX; txsr <= rd_data; sda_pull <= ~rd_data[DW-1]; end
            NX_CMD:   begin st <= ST_CMD;   sda_pull <= 1'b0; end
            NX_WDATA: begin st <= ST_WDATA; sda_pull <= 1'b0; end
            default:  begin st <= ST_IDLE;  sda_pull <= 1'b0; end
          endcase
        end
        ST_TX: if (scl_fall) begin
          if (cnt == LAST_TX) begin
            sda_pull <= 1'b0; st <= ST_IDLE; cnt <= '0;
          end else begin
            txsr <= {txsr[DW-2:0], 1'b0};
            sda_pull <= ~txsr[DW-2];
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] PREFIX      = 6'b010110,
  parameter logic [7:0] SEL_CTLA    = 8'h10,
  parameter logic [7:0] SEL_CTLB    = 8'h11,
  parameter logic [7:0] SEL_STAT    = 8'h13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          addr_strap,
  input  logic [DW-1:0] status_in,
  output logic          sda_pull,
  output logic [DW-1:0] ctl_a_q,
  output logic [DW-1:0] ctl_b_q
);
  logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_fire, ack_fire, tx_done, in_idle, in_addr;
  logic [7:0]    sel;
  logic [DW-1:0] wr_data, rd_data;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  tw_xfer_fsm #(.DW(DW), .PREFIX(PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(addr_strap), .rd_data(rd_data), .sda_pull(sda_pull),
    .sel(sel), .wr_data(wr_data), .wr_fire(wr_fire), .ack_fire(ack_fire),
    .tx_done(tx_done), .in_idle(in_idle), .in_addr(in_addr)
  );

  tw_reg_bank #(.DW(DW), .SEL_CTLA(SEL_CTLA), .SEL_CTLB(SEL_CTLB),
                .SEL_STAT(SEL_STAT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .sel(sel),
    .wr_data(wr_data), .status_in(status_in), .ctl_a(ctl_a_q),
    .ctl_b(ctl_b_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_pull,
  input logic          scl_lvl,
  input logic          start_det,
  input logic          in_addr,
  input logic          in_idle,
  input logic          wr_fire,
  input logic          ack_fire,
  input logic          tx_done,
  input logic [DW-1:0] ctl_a_q,
  input logic [DW-1:0] ctl_b_q
);
  // R2: an accepted byte is followed by the pull-low enable
  a_r2_ack_pulls: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> sda_pull);

  // R2: nothing is driven while waiting for a START
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_pull);

  // R3: control registers move only on a completed data byte
  a_r3_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ctl_a_q, ctl_b_q}) |-> $past(wr_fire));

  // R6: the last read bit is followed by release
  a_r6_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (!sda_pull && in_idle));

  // R7: START always restarts address reception
  a_r7_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> in_addr);

  // R8: output changes only during the low phase of SCL
  a_r8_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_lvl));
endmodule

bind tw_reg_slave tw_reg_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .scl_lvl(scl_lvl),
  .start_det(start_det), .in_addr(in_addr), .in_idle(in_idle),
  .wr_fire(wr_fire), .ack_fire(ack_fire), .tx_done(tx_done),
  .ctl_a_q(ctl_a_q), .ctl_b_q(ctl_b_q)
);

// File: tb/sim_tw_reg_slave.sv
module sim_tw_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic [7:0] status = 8'h00;
  logic sda_pull;
  logic [7:0] ctl_a, ctl_b;
  wire  sda_bus = sda_m & ~sda_pull;

  int n_chk = 0, n_bad = 0, r8_bad = 0;
  logic pull_prev = 1'b0;
  logic [7:0] exp_a = 8'h00, exp_b = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .addr_strap(strap), .status_in(status), .sda_pull(sda_pull),
    .ctl_a_q(ctl_a), .ctl_b_q(ctl_b)
  );

  // R8 monitor: the slave's output must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && (sda_pull !== pull_prev) && scl_m) r8_bad++;
    pull_prev <= sda_pull;
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic tick();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(); scl_m = 1'b1; tick();
    sda_m = 1'b0; tick(); scl_m = 1'b0; tick();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(); scl_m = 1'b1; tick(); sda_m = 1'b1; tick();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(); scl_m = 1'b1; tick(); tick(); scl_m = 1'b0; tick();
  endtask

  task automatic get_bit(output logic v);
    sda_m = 1'b1; tick(); scl_m = 1'b1; tick(); v = sda_bus; tick(); scl_m = 1'b0; tick();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(v);
    ack = !v;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(v);
      b[i] = v;
    end
    sda_m = 1'b1; tick(); scl_m = 1'b1; tick();
    check("R6 SDA released in host ack clock", sda_pull, 1'b0);
    tick(); scl_m = 1'b0; tick();
  endtask

  function automatic logic [7:0] dev(input logic s, input logic rd);
    return {6'b010110, s, rd};
  endfunction

  task automatic reg_write(input logic [7:0] sel, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(dev(strap, 1'b0), a0);
    send_byte(sel, a1);
    send_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic reg_read(input logic [7:0] sel, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(dev(strap, 1'b0), a0);
    send_byte(sel, a1);
    bus_start();
    send_byte(dev(strap, 1'b1), a2);
    recv_byte(d);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic t_reset();
    check("R1 ctl_a reset", ctl_a, 8'h00);
    check("R1 ctl_b reset", ctl_b, 8'h00);
    check("R1 SDA released", sda_pull, 1'b0);
  endtask

  task automatic t_write_read();
    logic ok; logic [7:0] d;
    reg_write(8'h10, 8'hA5, ok); exp_a = 8'hA5;
    check("R3 write 10h acked", ok, 1'b1);
    check("R3 ctl_a stored", ctl_a, exp_a);
    reg_write(8'h11, 8'h3C, ok); exp_b = 8'h3C;
    check("R3 write 11h acked", ok, 1'b1);
    check("R3 ctl_b stored", ctl_b, exp_b);
    reg_read(8'h10, d, ok);
    check("R4 read 10h acked", ok, 1'b1);
    check("R4 read 10h data", d, exp_a);
    reg_read(8'h11, d, ok);
    check("R4 read 11h data", d, exp_b);
    reg_read(8'h10, d, ok);
    check("R4 repeat read 10h data", d, exp_a);
  endtask

  task automatic t_status();
    logic ok; logic [7:0] d;
    status = 8'h5A;
    reg_read(8'h13, d, ok);
    check("R4 status read 5A", d, 8'h5A);
    status = 8'hC3;
    reg_read(8'h13, d, ok);
    check("R4 status read C3", d, 8'hC3);
  endtask

  task automatic t_discard();
    logic ok; logic [7:0] d;
    reg_write(8'h13, 8'h77, ok);
    check("R5 write 13h acked", ok, 1'b1);
    check("R5 ctl_a untouched by 13h", ctl_a, exp_a);
    check("R5 ctl_b untouched by 13h", ctl_b, exp_b);
    reg_read(8'h13, d, ok);
    check("R5 status still live", d, status);
    reg_write(8'h20, 8'hEE, ok);
    check("R5 unmapped write acked", ok, 1'b1);
    check("R5 ctl_a untouched by 20h", ctl_a, exp_a);
    check("R5 ctl_b untouched by 20h", ctl_b, exp_b);
    reg_read(8'h12, d, ok);
    check("R5 unmapped read zero", d, 8'h00);
  endtask

  task automatic t_addr();
    logic ack, ok; logic [7:0] d;
    bus_start();
    send_byte(dev(~strap, 1'b0), ack);
    check("R2 foreign address not acked", ack, 1'b0);
    send_byte(8'h10, ack);
    check("R2 no ack after foreign address", ack, 1'b0);
    send_byte(8'h11, ack);
    bus_stop();
    check("R2 ctl_a untouched", ctl_a, exp_a);
    strap = 1'b1; tick();
    reg_write(8'h11, 8'h6B, ok); exp_b = 8'h6B;
    check("R2 strapped address acked", ok, 1'b1);
    check("R2 strapped write stored", ctl_b, exp_b);
    reg_read(8'h11, d, ok);
    check("R2 strapped read", d, exp_b);
    bus_start();
    send_byte(dev(1'b0, 1'b0), ack);
    bus_stop();
    check("R2 old address rejected", ack, 1'b0);
    strap = 1'b0; tick();
  endtask

  task automatic t_abort();
    logic ack, a1, a2, a3;
    bus_start();
    send_byte(dev(strap, 1'b0), ack);
    send_byte(8'h10, ack);
    for (int i = 7; i >= 4; i--) put_bit(8'hF0 >> i);
    bus_stop();
    check("R7 STOP mid byte keeps ctl_a", ctl_a, exp_a);
    bus_start();
    send_byte(dev(strap, 1'b0), ack);
    send_byte(8'h11, ack);
    for (int i = 7; i >= 5; i--) put_bit(1'b0);
    bus_start();
    send_byte(dev(strap, 1'b0), a1);
    send_byte(8'h11, a2);
    send_byte(8'h99, a3);
    bus_stop();
    exp_b = 8'h99;
    check("R7 restart address acked", a1 & a2 & a3, 1'b1);
    check("R7 write after restart stored", ctl_b, exp_b);
    check("R7 ctl_a unchanged", ctl_a, exp_a);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_write_read();
    t_status();
    t_discard();
    t_addr();
    t_abort();
    check("R8 SDA changes during SCL high", r8_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule